// File: doc/BRIEF.md
# Delay-Slot Branch Target Unit

This unit works out the two upcoming program-counter values for a processor whose branches may carry a delay slot. Each transaction carries the following values: the address of the current instruction, the pending next address, the pending delayed address, the T condition flag, a general-register value, one 16-bit instruction word and a flag that says the word sits in a delay slot. The unit returns the updated next and delayed addresses. For subroutine forms it also returns a return address with a write enable. It raises an illegal-slot flag when a branch turns up inside a slot.

Transactions enter on a valid/ready handshake and leave on a second one, through a single output register. The upstream side may present a word when `in_ready` is high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. Once `out_valid` is high, the output fields stay frozen until `out_ready` is seen high at a clock edge. There is one cycle of latency from acceptance to `out_valid`.

Top module: `dslot_branch_unit`

## Requirements
- R1: After reset `out_valid` is low and `in_ready` is high.
- R2: PC-relative conditional targets equal pc + 4 + 2*sign-extended bits [7:0] of the word, including negative displacements.
- R3: A taken immediate conditional branch (high byte 0x8B or 0x89) gives next = target and delayed = target + 2. When it is not taken, both pass through unchanged.
- R4: A taken slotted conditional branch (high byte 0x8F or 0x8D) replaces only the delayed address with the target. The next address passes through unchanged.
- R5: High bytes 0x8B and 0x8F branch when T = 0. High bytes 0x89 and 0x8D branch when T = 1.
- R6: A word whose top nibble is 1010 loads the delayed address with pc + 4 + 2*sign-extended bits [11:0]. The next address is unchanged.
- R7: A word whose top nibble is 1011 does the same as R6 and also drives `ret_addr_o` = pc + 4 with `ret_we_o` = 1.
- R8: Words 0000xxxx00100011 and 0000xxxx00000011 load the delayed address with (pc + 4 + rn) with bit 0 cleared. The second form also writes the return address pc + 4.
- R9: Any branch form accepted with `in_slot_i` = 1 sets `illslot_o`. Both addresses then pass through unchanged and `ret_we_o` = 0.
- R10: Any other word passes both addresses through unchanged, with `ret_we_o` = 0, `ret_addr_o` = 0 and `illslot_o` = 0.
- R11: All address sums wrap modulo 2^ADDR_W.
- R12: `in_ready` = !`out_valid` || `out_ready`. While `out_valid` is high and `out_ready` is low, all outputs hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Transaction offered |
| in_ready | output | 1 | Transaction can be taken |
| pc_i | input | ADDR_W | Address of the branch word |
| npc_i | input | ADDR_W | Pending next address |
| dpc_i | input | ADDR_W | Pending delayed address |
| t_i | input | 1 | T condition flag |
| rn_i | input | ADDR_W | Register operand for register-relative forms |
| insn_i | input | 16 | Instruction word |
| in_slot_i | input | 1 | Word executes in a delay slot |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Result taken by downstream |
| npc_o | output | ADDR_W | Updated next address |
| dpc_o | output | ADDR_W | Updated delayed address |
| ret_addr_o | output | ADDR_W | Return address |
| ret_we_o | output | 1 | Return address write enable |
| illslot_o | output | 1 | Illegal-slot exception |

## Verification
The bench builds the unit with the default ADDR_W of 32. At that width the displacement sign bits reach the top of the word, so a pc near 0xFFFFFFFC shows modulo wrap on both the PC-relative and the register-relative paths. A 32-bit register operand with its low bit set shows the bit-0 clear. Random downstream stalls make the hold rule and the ready rule matter across directed and random words.

// File: rtl/bdu_pkg.sv
package bdu_pkg;
  localparam int INSN_W = 16;

  typedef enum logic [2:0] {
    BK_NONE,
    BK_COND_NOW,
    BK_COND_SLOT,
    BK_JUMP,
    BK_CALL,
    BK_JUMP_REG,
    BK_CALL_REG
  } br_kind_e;
endpackage

// File: rtl/bdu_decode.sv
module bdu_decode
  import bdu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [INSN_W-1:0] insn_i,
  output br_kind_e          kind_o,
  output logic              on_set_o,
  output logic [ADDR_W-1:0] disp_o
);
  localparam int SHORT_W = 8;
  localparam int LONG_W  = 12;

  logic [ADDR_W-1:0] disp_short;
  logic [ADDR_W-1:0] disp_long;

  assign disp_short = {{(ADDR_W-SHORT_W-1){insn_i[SHORT_W-1]}}, insn_i[SHORT_W-1:0], 1'b0};
  assign disp_long  = {{(ADDR_W-LONG_W-1){insn_i[LONG_W-1]}}, insn_i[LONG_W-1:0], 1'b0};

  always_comb begin
    kind_o   = BK_NONE;
    on_set_o = 1'b0;
    disp_o   = disp_short;
    casez (insn_i)
      16'b10001011????????: kind_o = BK_COND_NOW;
      16'b10001111????????: kind_o = BK_COND_SLOT;
      16'b10001001????????: begin kind_o = BK_COND_NOW;  on_set_o = 1'b1; end
      16'b10001101????????: begin kind_o = BK_COND_SLOT; on_set_o = 1'b1; end
      16'b1010????????????: begin kind_o = BK_JUMP; disp_o = disp_long; end
      16'b1011????????????: begin kind_o = BK_CALL; disp_o = disp_long; end
      16'b0000????00100011: kind_o = BK_JUMP_REG;
      16'b0000????00000011: kind_o = BK_CALL_REG;
      default:              kind_o = BK_NONE;
    endcase
  end
endmodule

// File: rtl/bdu_target.sv
module bdu_target #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] disp_i,
  input  logic [ADDR_W-1:0] rn_i,
  input  logic              reg_rel_i,
  output logic [ADDR_W-1:0] link_o,
  output logic [ADDR_W-1:0] target_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic [ADDR_W-1:0] sum;

  assign link_o = pc_i + STEP;
  assign sum    = link_o + (reg_rel_i ? rn_i : disp_i);

  always_comb begin
    target_o = sum;
    if (reg_rel_i) target_o[0] = 1'b0;
  end
endmodule

// File: rtl/dslot_branch_unit.sv
module dslot_branch_unit
  import bdu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] npc_i,
  input  logic [ADDR_W-1:0] dpc_i,
  input  logic              t_i,
  input  logic [ADDR_W-1:0] rn_i,
  input  logic [15:0]       insn_i,
  input  logic              in_slot_i,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] npc_o,
  output logic [ADDR_W-1:0] dpc_o,
  output logic [ADDR_W-1:0] ret_addr_o,
  output logic              ret_we_o,
  output logic              illslot_o
);
  localparam logic [ADDR_W-1:0] HALF_STEP = ADDR_W'(2);

  br_kind_e          kind;
  logic              on_set;
  logic [ADDR_W-1:0] disp;
  logic [ADDR_W-1:0] link;
  logic [ADDR_W-1:0] target;
  logic              reg_rel;

  bdu_decode #(.ADDR_W(ADDR_W)) dec_i (
    .insn_i   (insn_i),
    .kind_o   (kind),
    .on_set_o (on_set),
    .disp_o   (disp)
  );

  assign reg_rel = (kind == BK_JUMP_REG) || (kind == BK_CALL_REG);

  bdu_target #(.ADDR_W(ADDR_W)) tgt_i (
    .pc_i      (pc_i),
    .disp_i    (disp),
    .rn_i      (rn_i),
    .reg_rel_i (reg_rel),
    .link_o    (link),
    .target_o  (target)
  );

  logic [ADDR_W-1:0] nx_npc, nx_dpc, nx_ret;
  logic              nx_we, nx_ill, taken;

  assign taken = (t_i == on_set);

  always_comb begin
    nx_npc = npc_i;
    nx_dpc = dpc_i;
    nx_ret = '0;
    nx_we  = 1'b0;
    nx_ill = 1'b0;
    if (kind != BK_NONE && in_slot_i) begin
      nx_ill = 1'b1;
    end else begin
      unique case (kind)
        BK_COND_NOW: if (taken) begin
          nx_npc = target;
          nx_dpc = target + HALF_STEP;
        end
        BK_COND_SLOT: if (taken) nx_dpc = target;
        BK_JUMP, BK_JUMP_REG: nx_dpc = target;
        BK_CALL, BK_CALL_REG: begin
          nx_dpc = target;
          nx_ret = link;
          nx_we  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      npc_o      <= '0;
      dpc_o      <= '0;
      ret_addr_o <= '0;
      ret_we_o   <= 1'b0;
      illslot_o  <= 1'b0;
    end else if (in_valid && in_ready) begin
      out_valid  <= 1'b1;
      npc_o      <= nx_npc;
      dpc_o      <= nx_dpc;
      ret_addr_o <= nx_ret;
      ret_we_o   <= nx_we;
      illslot_o  <= nx_ill;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/dslot_branch_unit_chk.sv
module dslot_branch_unit_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ADDR_W-1:0] pc_i,
  input logic [ADDR_W-1:0] npc_i,
  input logic [ADDR_W-1:0] dpc_i,
  input logic [15:0]       insn_i,
  input logic              in_slot_i,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] npc_o,
  input logic [ADDR_W-1:0] dpc_o,
  input logic [ADDR_W-1:0] ret_addr_o,
  input logic              ret_we_o,
  input logic              illslot_o
);
  logic acc;
  assign acc = in_valid && in_ready;

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(npc_o) && $stable(dpc_o)
      && $stable(ret_addr_o) && $stable(ret_we_o) && $stable(illslot_o));

  a_r12_accept: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  a_r9_slot_jump: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_slot_i && insn_i[15:13] == 3'b101 |=>
      illslot_o && !ret_we_o && npc_o == $past(npc_i) && dpc_o == $past(dpc_i));

  a_r10_plain: assert property (@(posedge clk) disable iff (!rst_n)
    acc && insn_i[15:12] == 4'b0110 |=>
      !illslot_o && !ret_we_o && npc_o == $past(npc_i) && dpc_o == $past(dpc_i));

  a_r7_link: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_slot_i && insn_i[15:12] == 4'b1011 |=>
      ret_we_o && ret_addr_o == $past(pc_i) + ADDR_W'(4));

  a_r3_pair: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_slot_i && (insn_i[15:8] == 8'h8B || insn_i[15:8] == 8'h89) |=>
      (dpc_o == npc_o + ADDR_W'(2)) || (npc_o == $past(npc_i) && dpc_o == $past(dpc_i)));
endmodule

bind dslot_branch_unit dslot_branch_unit_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .pc_i       (pc_i),
  .npc_i      (npc_i),
  .dpc_i      (dpc_i),
  .insn_i     (insn_i),
  .in_slot_i  (in_slot_i),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .npc_o      (npc_o),
  .dpc_o      (dpc_o),
  .ret_addr_o (ret_addr_o),
  .ret_we_o   (ret_we_o),
  .illslot_o  (illslot_o)
);

// File: tb/dslot_branch_unit_tb_top.sv
`timescale 1ns/1ps
module dslot_branch_unit_tb_top;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          in_valid = 1'b0, in_ready, t_i = 1'b0, in_slot_i = 1'b0;
  logic [AW-1:0] pc_i = '0, npc_i = '0, dpc_i = '0, rn_i = '0;
  logic [15:0]   insn_i = '0;
  logic          out_valid, out_ready = 1'b1, ret_we_o, illslot_o;
  logic [AW-1:0] npc_o, dpc_o, ret_addr_o;

  dslot_branch_unit #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .pc_i(pc_i), .npc_i(npc_i), .dpc_i(dpc_i), .t_i(t_i), .rn_i(rn_i),
    .insn_i(insn_i), .in_slot_i(in_slot_i), .out_valid(out_valid),
    .out_ready(out_ready), .npc_o(npc_o), .dpc_o(dpc_o),
    .ret_addr_o(ret_addr_o), .ret_we_o(ret_we_o), .illslot_o(illslot_o)
  );

  typedef struct {
    logic [AW-1:0] npc, dpc, ret;
    logic          we, ill;
    string         tag;
  } exp_t;

  exp_t sb[$];
  int   checks = 0, errors = 0;
  bit   stall_mode = 1'b0, done = 1'b0;

  function automatic exp_t model(logic [AW-1:0] pc, npc, dpc, rn, logic t,
                                 logic [15:0] w, logic slot, string tag);
    exp_t e;
    logic [AW-1:0] base, tgt;
    logic cond, far, regrel;
    e.npc = npc; e.dpc = dpc; e.ret = '0; e.we = 1'b0; e.ill = 1'b0; e.tag = tag;
    base   = pc + 32'd4;
    cond   = (w[15:8] == 8'h8B) || (w[15:8] == 8'h8F) || (w[15:8] == 8'h89) || (w[15:8] == 8'h8D);
    far    = (w[15:13] == 3'b101);
    regrel = (w[15:12] == 4'h0) && ((w[7:0] == 8'h23) || (w[7:0] == 8'h03));
    if (!(cond || far || regrel)) return e;
    if (slot) begin e.ill = 1'b1; return e; end
    if (cond) begin
      tgt = base + {{23{w[7]}}, w[7:0], 1'b0};
      if (t == !w[9]) begin
        if (w[10]) e.dpc = tgt;
        else begin e.npc = tgt; e.dpc = tgt + 32'd2; end
      end
    end else if (far) begin
      e.dpc = base + {{19{w[11]}}, w[11:0], 1'b0};
      if (w[12]) begin e.ret = base; e.we = 1'b1; end
    end else begin
      tgt = base + rn;
      e.dpc = {tgt[AW-1:1], 1'b0};
      if (w[7:0] == 8'h03) begin e.ret = base; e.we = 1'b1; end
    end
    return e;
  endfunction

  task automatic send(logic [AW-1:0] pc, npc, dpc, rn, logic t,
                      logic [15:0] w, logic slot, string tag);
    @(negedge clk);
    in_valid = 1'b1; pc_i = pc; npc_i = npc; dpc_i = dpc; rn_i = rn;
    t_i = t; insn_i = w; in_slot_i = slot;
    #2;
    while (!in_ready) begin @(negedge clk); #2; end
    sb.push_back(model(pc, npc, dpc, rn, t, w, slot, tag));
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // monitor: drives out_ready, pops expected items on each output transfer
  logic [AW-1:0] held_npc, held_dpc;
  bit            hold_pending = 1'b0;
  always begin
    @(negedge clk);
    if (hold_pending) begin
      checks++;
      if (!out_valid || npc_o !== held_npc || dpc_o !== held_dpc) begin
        errors++;
        $display("FAIL R12 hold: npc=%h dpc=%h expected npc=%h dpc=%h", npc_o, dpc_o, held_npc, held_dpc);
      end
      hold_pending = 1'b0;
    end
    out_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
    #1;
    if (out_valid && !out_ready) begin
      held_npc = npc_o; held_dpc = dpc_o; hold_pending = 1'b1;
    end
    if (out_valid && out_ready) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R12 unexpected output: npc=%h expected none", npc_o);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (npc_o !== e.npc || dpc_o !== e.dpc || ret_addr_o !== e.ret ||
            ret_we_o !== e.we || illslot_o !== e.ill) begin
          errors++;
          $display("FAIL %s: got npc=%h dpc=%h ret=%h we=%b ill=%b expected npc=%h dpc=%h ret=%h we=%b ill=%b",
                   e.tag, npc_o, dpc_o, ret_addr_o, ret_we_o, illslot_o,
                   e.npc, e.dpc, e.ret, e.we, e.ill);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  localparam logic [AW-1:0] NP = 32'h0000_1002, DP = 32'h0000_1004;

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset: out_valid=%b in_ready=%b expected 0 1", out_valid, in_ready);
    end
    rst_n = 1'b1;

    send(32'h1000, NP, DP, 0, 1'b1, 16'h8910, 1'b0, "R3 R5 R2 true-cond taken");
    send(32'h1000, NP, DP, 0, 1'b0, 16'h8910, 1'b0, "R3 R5 true-cond not taken");
    send(32'h1000, NP, DP, 0, 1'b0, 16'h8BF0, 1'b0, "R3 R5 R2 false-cond taken neg disp");
    send(32'h1000, NP, DP, 0, 1'b1, 16'h8BF0, 1'b0, "R3 R5 false-cond not taken");
    send(32'h2000, NP, DP, 0, 1'b1, 16'h8D7F, 1'b0, "R4 R5 slotted true-cond taken");
    send(32'h2000, NP, DP, 0, 1'b0, 16'h8F80, 1'b0, "R4 R5 R2 slotted false-cond taken");
    send(32'h2000, NP, DP, 0, 1'b1, 16'h8F80, 1'b0, "R4 slotted false-cond not taken");
    send(32'h3000, NP, DP, 0, 1'b0, 16'hA7FF, 1'b0, "R6 jump max positive");
    send(32'h3000, NP, DP, 0, 1'b0, 16'hA800, 1'b0, "R6 jump max negative");
    send(32'h4000, NP, DP, 0, 1'b0, 16'hB010, 1'b0, "R7 call");
    send(32'h5000, NP, DP, 32'h0000_0101, 1'b0, 16'h0523, 1'b0, "R8 reg jump odd rn");
    send(32'h5000, NP, DP, 32'hFFFF_FF01, 1'b0, 16'h0A03, 1'b0, "R8 reg call neg rn");
    send(32'h6000, NP, DP, 0, 1'b0, 16'hA010, 1'b1, "R9 jump in slot");
    send(32'h6000, NP, DP, 0, 1'b1, 16'h8910, 1'b1, "R9 cond in slot");
    send(32'h6000, NP, DP, 0, 1'b0, 16'h0303, 1'b1, "R9 reg call in slot");
    send(32'h7000, NP, DP, 0, 1'b1, 16'h6003, 1'b0, "R10 plain word");
    send(32'h7000, NP, DP, 0, 1'b1, 16'h0013, 1'b0, "R10 near-miss reg form");
    send(32'h7000, NP, DP, 0, 1'b1, 16'h8A10, 1'b0, "R10 near-miss cond byte");
    send(32'hFFFF_FFFC, NP, DP, 0, 1'b1, 16'h8904, 1'b0, "R11 wrap cond");
    send(32'hFFFF_FFF0, NP, DP, 32'h0000_0021, 1'b0, 16'h0123, 1'b0, "R11 wrap reg jump");

    stall_mode = 1'b1;
    for (int i = 0; i < 300; i++) begin
      logic [15:0] w;
      int sel;
      sel = $urandom % 6;
      w = 16'($urandom);
      case (sel)
        0: w[15:8] = 8'h89;
        1: w[15:8] = 8'h8B;
        2: w[15:8] = 8'h8D;
        3: w[15:8] = 8'h8F;
        4: w[7:0]  = (w[0] ? 8'h23 : 8'h03);
        default: ;
      endcase
      if (sel == 4) w[15:12] = 4'h0;
      send($urandom, $urandom, $urandom, $urandom, 1'($urandom),
           w, (($urandom % 8) == 0), "R12 random under back-pressure");
    end

    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule